// File: doc/BRIEF.md
# Compare-Match Wakeup Timer

A free-running low-frequency counter that advances once per tick of a slow time base. Each tick arrives as a single-cycle enable pulse, and one of two tick inputs is chosen by a control bit. The count is compared with a programmable compare value. When the counter arrives at that value, a sticky match flag is set. The flag drives an interrupt line when interrupts are enabled. It separately drives a deep-sleep wakeup request when wakeup is enabled. Each output has its own enable bit, so either can be used without the other.

Software uses a small register interface with four locations: control, count, compare and flag. Writes take effect on the clock edge, and reads are combinational on the same address lines. Counting starts only when the run bit is set. For a period of N ticks, software clears the count to zero, writes N-1 to the compare register and turns on wrap mode. In wrap mode the counter returns to zero on the tick after it reaches the compare value. Without wrap mode the counter runs on and rolls over at its full width.

Top module: `cmw_timer`

## Requirements
- R1: After reset, every readable location (control, count, compare, flag) reads zero, and `irq` and `wake_req` are low. The flag stays clear until the count or the compare value changes.
- R2: The counter advances by one per selected tick only while the run bit (control bit 0) is 1. With run at 0, ticks leave the count unchanged.
- R3: Control bit 4 selects the tick source: 0 selects `tick_fast` and 1 selects `tick_slow`. Pulses on the other tick input have no effect on the count.
- R4: When the counter holds a value equal to the compare value, the flag (read at address 3, bit 0) is set on the following clock edge. It then stays set until software clears it.
- R5: A match is taken once per arrival of the count at the compare value. If the flag is cleared while the count remains on the compare value, the flag stays clear until the count or the compare value is written or the count advances.
- R6: With wrap mode (control bit 1) set, a tick while count equals compare loads the count with 0, giving a period of compare+1 ticks. With wrap mode clear, the count rolls over from all ones to 0.
- R7: `irq` is high exactly when the flag is set and the interrupt enable (control bit 2) is 1.
- R8: `wake_req` is high exactly when the flag is set and the wakeup enable (control bit 3) is 1, regardless of the interrupt enable. It stays high until the flag is cleared.
- R9: Writing address 3 with bit 0 at 1 clears the flag, and writing it with bit 0 at 0 has no effect. If a match occurs in the same cycle as a clear, the flag stays set.
- R10: A write to the count (address 1) loads the written value, even when a tick occurs in the same cycle.
- R11: A write to the compare register (address 2) replaces the compare value, which then reads back at address 2. A write to the control register (address 0) reads back in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Single-cycle tick pulse from the fast slow-clock rate (for example 32768 Hz) |
| tick_slow | input | 1 | Single-cycle tick pulse from the slower rate (for example 1000 Hz) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 count, 2 compare, 3 flag |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request, the flag gated by the interrupt enable |
| wake_req | output | 1 | Deep-sleep wakeup request, the flag gated by the wakeup enable |

## Verification
The bench builds the timer with an 8-bit counter. This keeps the natural rollover from 255 to 0 within a couple of ticks of a directed load. It also means random count and compare writes land on each other often, so many match events occur. Directed cases cover:
- a match colliding with a flag clear;
- a count write colliding with a tick;
- a flag cleared while the count sits still on the compare value;
- wrap-mode periods of ten ticks.

Several thousand random cycles then mix register writes, both tick inputs and every control combination.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_CMP   = 2'd2,
        REG_FLAG  = 2'd3
    } reg_sel_e;

    // bit 0 run, bit 1 wrap, bit 2 irq enable, bit 3 wake enable, bit 4 tick select
    typedef struct packed {
        logic tick_sel;
        logic wake_en;
        logic irq_en;
        logic wrap_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic ctrl_we;
        logic count_we;
        logic cmp_we;
        logic flag_clr;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [1:0] a,
                                             input logic clr_bit);
        wr_dec_t d;
        d = '0;
        if (we) begin
            case (reg_sel_e'(a))
                REG_CTRL:  d.ctrl_we  = 1'b1;
                REG_COUNT: d.count_we = 1'b1;
                REG_CMP:   d.cmp_we   = 1'b1;
                REG_FLAG:  d.flag_clr = clr_bit;
                default:   d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/cmw_regs.sv
module cmw_regs
    import cmw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp,
    output logic             count_we,
    output logic             cmp_we,
    output logic             flag_clr
);

    wr_dec_t dec;

    always_comb begin
        dec      = decode_write(wr_en, addr, wr_data[0]);
        count_we = dec.count_we;
        cmp_we   = dec.cmp_we;
        flag_clr = dec.flag_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cmp  <= '0;
        end else begin
            if (dec.ctrl_we) ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (dec.cmp_we)  cmp  <= wr_data;
        end
    end

    // R11
    cmp_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> cmp == $past(wr_data));

endmodule

// File: rtl/cmw_counter.sv
module cmw_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wrap_en,
    input  logic             tick_sel,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             moved
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic tick_now;
    logic at_cmp;

    assign tick_now = run & (tick_sel ? tick_slow : tick_fast);
    assign at_cmp   = (cnt == cmp);
    assign moved    = load | tick_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick_now) begin
            cnt <= (wrap_en && at_cmp) ? ZERO : cnt + ONE;
        end
    end

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(cnt));

    // R3
    unselected_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick_sel && !tick_fast) |=> $stable(cnt));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && run && wrap_en && at_cmp && (tick_sel ? tick_slow : tick_fast))
        |=> cnt == ZERO);

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));

endmodule

// File: rtl/cmw_match.sv
module cmw_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             rearm,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             wake_en,
    output logic             flag,
    output logic             irq,
    output logic             wake_req
);

    logic armed;
    logic hit;

    assign hit      = armed & (cnt == cmp);
    assign irq      = flag & irq_en;
    assign wake_req = flag & wake_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (rearm)    armed <= 1'b1;
            else if (hit) armed <= 1'b0;
            flag <= hit | (flag & ~flag_clr);
        end
    end

    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cnt == cmp));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R5
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !rearm) |=> !hit);

endmodule

// File: rtl/cmw_timer.sv
module cmw_timer
    import cmw_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             wake_req
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic             count_we;
    logic             cmp_we;
    logic             flag_clr;
    logic             moved;
    logic             flag;

    cmw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .cmp      (cmp),
        .count_we (count_we),
        .cmp_we   (cmp_we),
        .flag_clr (flag_clr)
    );

    cmw_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .wrap_en   (ctrl.wrap_en),
        .tick_sel  (ctrl.tick_sel),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .load      (count_we),
        .load_val  (wr_data),
        .cmp       (cmp),
        .cnt       (cnt),
        .moved     (moved)
    );

    cmw_match #(.CNT_W(CNT_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .cmp      (cmp),
        .rearm    (moved | cmp_we),
        .flag_clr (flag_clr),
        .irq_en   (ctrl.irq_en),
        .wake_en  (ctrl.wake_en),
        .flag     (flag),
        .irq      (irq),
        .wake_req (wake_req)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            REG_CTRL:  rd_data = CNT_W'(ctrl);
            REG_COUNT: rd_data = cnt;
            REG_CMP:   rd_data = cmp;
            default:   rd_data = CNT_W'(flag);
        endcase
    end

endmodule

// File: tb/cmw_timer_test.sv
`timescale 1ns/100ps
module cmw_timer_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_fast = 1'b0;
    logic         tick_slow = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         irq;
    logic         wake_req;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    // reference state
    logic [W-1:0] m_cnt, m_cmp;
    logic [4:0]   m_ctrl;
    logic         m_flag, m_armed;

    always #2 clk = ~clk;

    cmw_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .wake_req(wake_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_cnt(input logic ld, input logic [W-1:0] d,
                                               input logic tk);
        if (ld) return d;
        if (tk) return (m_ctrl[1] && m_cnt == m_cmp) ? '0 : m_cnt + 1'b1;
        return m_cnt;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_cmp = '0; m_ctrl = '0; m_flag = 1'b0; m_armed = 1'b0;
    endtask

    // one clock cycle; called at a falling edge
    task automatic step(input bit we, input bit [1:0] a, input bit [W-1:0] d,
                        input bit tf, input bit ts);
        logic tk, hit, ld, cw, clr;
        wr_en = we; addr = a; wr_data = d; tick_fast = tf; tick_slow = ts;
        @(posedge clk);
        tk  = m_ctrl[0] && (m_ctrl[4] ? ts : tf);
        hit = m_armed && (m_cnt == m_cmp);
        ld  = we && a == 2'd1;
        cw  = we && a == 2'd2;
        clr = we && a == 2'd3 && d[0];
        m_cnt   = next_cnt(ld, d, tk);
        m_armed = (ld || tk || cw) ? 1'b1 : (hit ? 1'b0 : m_armed);
        m_flag  = hit | (m_flag & ~clr);
        if (cw) m_cmp = d;
        if (we && a == 2'd0) m_ctrl = d[4:0];
        @(negedge clk);
        wr_en = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
        chk("R7 irq", int'(irq), int'(m_flag & m_ctrl[2]));
        chk("R8 wake_req", int'(wake_req), int'(m_flag & m_ctrl[3]));
    endtask

    task automatic rd(input bit [1:0] a, input int exp, input string req);
        addr = a;
        #0.5;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (198000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7731);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 0, "R1 ctrl");
        rd(2'd1, 0, "R1 count");
        rd(2'd2, 0, "R1 compare");
        rd(2'd3, 0, "R1 flag");
        chk("R1 irq", int'(irq), 0);
        chk("R1 wake_req", int'(wake_req), 0);
        idle(3);
        rd(2'd3, 0, "R1 flag stays clear");

        // R2 no counting before run
        for (int i = 0; i < 3; i++) step(1'b0, 2'd0, '0, 1'b1, 1'b0);
        rd(2'd1, 0, "R2 halted");
        step(1'b1, 2'd0, 8'h01, 1'b0, 1'b0);
        rd(2'd0, 1, "R11 ctrl readback");
        for (int i = 0; i < 5; i++) step(1'b0, 2'd0, '0, 1'b1, 1'b0);
        rd(2'd1, 5, "R2 five ticks");

        // R3 tick select
        for (int i = 0; i < 3; i++) step(1'b0, 2'd0, '0, 1'b0, 1'b1);
        rd(2'd1, 5, "R3 slow ignored");
        step(1'b1, 2'd0, 8'h11, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) step(1'b0, 2'd0, '0, 1'b1, 1'b0);
        rd(2'd1, 5, "R3 fast ignored");
        for (int i = 0; i < 2; i++) step(1'b0, 2'd0, '0, 1'b0, 1'b1);
        rd(2'd1, 7, "R3 slow counts");

        // R10 count write beats tick
        step(1'b1, 2'd1, 8'd40, 1'b0, 1'b1);
        rd(2'd1, 40, "R10 load priority");

        // R4 R5 match, flag, single hit
        step(1'b1, 2'd2, 8'd42, 1'b0, 1'b0);
        rd(2'd2, 42, "R11 compare readback");
        step(1'b1, 2'd0, 8'h15, 1'b0, 1'b0);
        step(1'b0, 2'd0, '0, 1'b0, 1'b1);
        step(1'b0, 2'd0, '0, 1'b0, 1'b1);
        rd(2'd1, 42, "R4 count at compare");
        rd(2'd3, 0, "R4 flag not yet");
        idle(1);
        rd(2'd3, 1, "R4 flag set");
        chk("R7 irq on match", int'(irq), 1);
        chk("R8 wake off", int'(wake_req), 0);
        idle(2);
        rd(2'd3, 1, "R4 flag sticky");
        step(1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
        rd(2'd3, 0, "R9 flag cleared");
        idle(3);
        rd(2'd3, 0, "R5 no second hit");

        // R9 write with bit0 clear, R8 wake gating
        step(1'b1, 2'd1, 8'd41, 1'b0, 1'b0);
        step(1'b0, 2'd0, '0, 1'b0, 1'b1);
        idle(1);
        rd(2'd3, 1, "R4 flag set again");
        step(1'b1, 2'd3, 8'h02, 1'b0, 1'b0);
        rd(2'd3, 1, "R9 bit0 zero ignored");
        step(1'b1, 2'd0, 8'h1D, 1'b0, 1'b0);
        chk("R8 wake on", int'(wake_req), 1);
        step(1'b1, 2'd0, 8'h19, 1'b0, 1'b0);
        chk("R8 wake without irq_en", int'(wake_req), 1);
        chk("R7 irq disabled", int'(irq), 0);
        idle(2);
        chk("R8 wake level held", int'(wake_req), 1);
        step(1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
        chk("R8 wake drops on clear", int'(wake_req), 0);

        // R6 wrap period of ten ticks
        step(1'b1, 2'd0, 8'h07, 1'b0, 1'b0);
        step(1'b1, 2'd2, 8'd9, 1'b0, 1'b0);
        step(1'b1, 2'd1, 8'd0, 1'b0, 1'b0);
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 10; i++) step(1'b0, 2'd0, '0, 1'b1, 1'b0);
            rd(2'd1, 0, "R6 wrapped to zero");
            rd(2'd3, 1, "R6 flag per period");
            step(1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
        end

        // R6 natural rollover without wrap
        step(1'b1, 2'd0, 8'h01, 1'b0, 1'b0);
        step(1'b1, 2'd1, 8'd254, 1'b0, 1'b0);
        step(1'b0, 2'd0, '0, 1'b1, 1'b0);
        step(1'b0, 2'd0, '0, 1'b1, 1'b0);
        rd(2'd1, 0, "R6 rollover");

        // R9 match and clear in the same cycle
        step(1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
        step(1'b1, 2'd1, 8'd9, 1'b0, 1'b0);
        step(1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
        rd(2'd3, 1, "R9 match wins over clear");

        // random phase against the reference model
        for (int n = 0; n < 4000; n++) begin
            bit we;
            bit [1:0] a;
            bit [W-1:0] d;
            we = ($urandom % 8) == 0;
            a  = 2'($urandom % 4);
            d  = (a == 2'd0) ? W'($urandom % 32) :
                 (a == 2'd3) ? W'($urandom % 4) : W'($urandom % 24);
            step(we, a, d, 1'($urandom % 2), 1'($urandom % 2));
            rd(2'd1, int'(m_cnt), "R2 R6 R10 random count");
            rd(2'd3, int'(m_flag), "R4 R5 R9 random flag");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule